// File: doc/BRIEF.md
# Pipelined Residue Multiplier Modulo 2^N − K

This block multiplies two N-bit operands and returns their product reduced modulo 2^N − K, a form of modulus used by the channels of a residue number system. Each input may be any N-bit value, including values at or above the modulus. The result is always fully reduced. The pipeline takes one operand pair per clock. The product is built in two stages. In the general case three more stages reduce it. These stages use the congruence 2^N ≡ K twice: the upper half of a word is scaled by K and added back to the lower half. A last stage then corrects the range. When K = 1, the reduction becomes one end-around addition in a single stage.

Operands come in on a valid/ready stream and results leave on another. A transfer happens on a rising clock edge where valid and ready are both high. The input side is ready whenever the output holds nothing or the consumer is ready. When a held result is not taken, the whole pipeline freezes. The output keeps its value, and no new operand is taken until the result is consumed. A cycle with no valid input passes through the pipeline as an empty slot, so results leave in the order their operands arrived.

The parameters must satisfy K ≥ 1 and K·(K+1) < 2^N. This bound is slightly tighter than log2(K) ≤ N/2, and elaboration stops if it is broken.

Top module: `mod_mul_pipe`

## Requirements
- R1: For every accepted pair (in_a, in_b), exactly one result equal to (in_a · in_b) mod (2^N − K) leaves the block, and results leave in acceptance order.
- R2: For K > 1 with out_ready held high, a result is presented on out_valid after the 5th rising edge, counting the accepting edge as the first.
- R3: For K = 1 with out_ready held high, a result is presented after the 3rd rising edge, counting the accepting edge as the first.
- R4: Every presented out_res is strictly below 2^N − K. For K = 1 the all-ones word never appears: a product congruent to zero, such as (2^N−1)·(2^N−1), gives 0.
- R5: With out_ready high, an unbroken run of valid inputs on consecutive cycles yields results on the same number of consecutive cycles, and no more results are ever in flight than the latency.
- R6: While out_valid is high and out_ready is low, out_valid stays high, out_res holds its value, and in_ready is low.
- R7: An input cycle with in_valid low produces a cycle with out_valid low, exactly one latency later.
- R8: After reset is released and before any input is taken, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present on in_a and in_b |
| in_ready | output | 1 | Block takes an operand pair on this edge |
| in_a | input | N | First operand, any N-bit value |
| in_b | input | N | Second operand, any N-bit value |
| out_valid | output | 1 | out_res holds a result |
| out_ready | input | 1 | Consumer takes out_res on this edge |
| out_res | output | N | Reduced product, below 2^N − K |

## Verification
The assertions assume that the consumer and producer follow the valid/ready rules. They also assume that out_ready is known on every edge after reset, since the in-flight count and the hold check depend on it. The directed stimulus runs four instances with N = 18 and K = 1, 3, 17 and 45, using operand values chosen to push every fold to its largest carry. Only the K = 3 instance has its out_ready randomly dropped, while the producer holds its operands until they are taken. The other instances see out_ready tied high, so the stall conditions are reached without breaking the handshake on any instance.

// File: rtl/mm_pkg.sv
package mm_pkg;

  // Bits needed to hold the constant K.
  function automatic int scale_bits(input int k);
    return $clog2(k + 1);
  endfunction

  // Pipeline depth: two product stages, then one fold stage for K = 1
  // or three reduction stages otherwise.
  function automatic int pipe_depth(input int k);
    return (k == 1) ? 3 : 5;
  endfunction

endpackage

// File: rtl/mm_product.sv
// Two-stage binary product: operand A is split in halves, each half times B
// is registered, then the two partial products are aligned and summed.
module mm_product #(
  parameter int N = 18
) (
  input  logic           clk,
  input  logic           en,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int HN  = N / 2;
  localparam int LOW = HN + N;
  localparam int HIW = (N - HN) + N;
  localparam int PW  = 2 * N;

  logic [LOW-1:0] lo_pp;
  logic [HIW-1:0] hi_pp;

  always_ff @(posedge clk) begin
    if (en) begin
      lo_pp <= LOW'(a[HN-1:0]) * LOW'(b);
      hi_pp <= HIW'(a[N-1:HN]) * HIW'(b);
    end
  end

  always_ff @(posedge clk) begin
    if (en) p <= (PW'(hi_pp) << HN) + PW'(lo_pp);
  end
endmodule

// File: rtl/mm_fold_stage.sv
// One fold: the word above bit N is scaled by K (since 2^N is congruent to K),
// the low N bits are passed on separately. Both are registered.
module mm_fold_stage #(
  parameter int N  = 18,
  parameter int K  = 3,
  parameter int IW = 36,
  localparam int KW  = mm_pkg::scale_bits(K),
  localparam int HKW = (IW - N) + KW
) (
  input  logic           clk,
  input  logic           en,
  input  logic [IW-1:0]  x,
  output logic [HKW-1:0] hi_k,
  output logic [N-1:0]   lo
);
  always_ff @(posedge clk) begin
    if (en) begin
      hi_k <= HKW'(x[IW-1:N]) * HKW'(K);
      lo   <= x[N-1:0];
    end
  end
endmodule

// File: rtl/mm_range_fix.sv
// Final stage: add the three congruent terms and subtract the modulus at most
// twice; the term bounds keep the sum below three times the modulus.
module mm_range_fix #(
  parameter int N  = 18,
  parameter int K  = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic [N-1:0]  t_a,
  input  logic [N-1:0]  t_b,
  input  logic [CW-1:0] t_c,
  output logic [N-1:0]  res
);
  localparam int SW = N + 2;
  localparam logic [SW-1:0] MODV = SW'((64'd1 << N) - 64'(K));

  logic [SW-1:0] sum, once, twice;

  always_comb begin
    sum   = SW'(t_a) + SW'(t_b) + SW'(t_c);
    once  = (sum  >= MODV) ? sum  - MODV : sum;
    twice = (once >= MODV) ? once - MODV : once;
  end

  always_ff @(posedge clk) begin
    if (en) res <= N'(twice);
  end
endmodule

// File: rtl/mm_end_around.sv
// K = 1 reduction: high half plus low half with the carry wrapped back in;
// the all-ones word is the second code for zero and is replaced by 0.
module mm_end_around #(
  parameter int N = 18
) (
  input  logic           clk,
  input  logic           en,
  input  logic [2*N-1:0] p,
  output logic [N-1:0]   res
);
  logic [N:0]   s;
  logic [N-1:0] t;

  always_comb begin
    s = (N+1)'(p[2*N-1:N]) + (N+1)'(p[N-1:0]);
    t = N'(s) + N'(s[N]);
  end

  always_ff @(posedge clk) begin
    if (en) res <= (t == '1) ? '0 : t;
  end
endmodule

// File: rtl/mod_mul_pipe.sv
module mod_mul_pipe #(
  parameter int N = 18,
  parameter int K = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_res
);
  localparam int LAT = mm_pkg::pipe_depth(K);
  localparam int KW  = mm_pkg::scale_bits(K);

  if (K < 1 || (longint'(K) * longint'(K + 1)) >= (longint'(1) << N)) begin : g_bad_params
    $error("mod_mul_pipe: K must satisfy 1 <= K and K*(K+1) < 2^N");
  end

  // Whole-pipeline advance: freeze only when a held result is refused.
  logic en;
  assign en       = out_ready | ~out_valid;
  assign in_ready = en;

  logic [LAT-1:0] vld;
  always_ff @(posedge clk) begin
    if (!rst_n)  vld <= '0;
    else if (en) vld <= {vld[LAT-2:0], in_valid};
  end
  assign out_valid = vld[LAT-1];

  logic [2*N-1:0] prod;
  mm_product #(.N(N)) u_product (
    .clk(clk), .en(en), .a(in_a), .b(in_b), .p(prod)
  );

  if (K == 1) begin : g_short
    mm_end_around #(.N(N)) u_end_around (
      .clk(clk), .en(en), .p(prod), .res(out_res)
    );
  end else begin : g_full
    logic [N+KW-1:0] f1_hi;
    logic [N-1:0]    f1_lo;
    logic [2*KW-1:0] f2_hi;
    logic [N-1:0]    f2_lo;
    logic [N-1:0]    f1_lo_d;

    mm_fold_stage #(.N(N), .K(K), .IW(2*N)) u_fold1 (
      .clk(clk), .en(en), .x(prod), .hi_k(f1_hi), .lo(f1_lo)
    );

    mm_fold_stage #(.N(N), .K(K), .IW(N+KW)) u_fold2 (
      .clk(clk), .en(en), .x(f1_hi), .hi_k(f2_hi), .lo(f2_lo)
    );

    // Low half of the product waits one stage alongside the second fold.
    always_ff @(posedge clk) begin
      if (en) f1_lo_d <= f1_lo;
    end

    mm_range_fix #(.N(N), .K(K), .CW(2*KW)) u_range_fix (
      .clk(clk), .en(en), .t_a(f1_lo_d), .t_b(f2_lo), .t_c(f2_hi),
      .res(out_res)
    );
  end
endmodule

// File: rtl/mod_mul_pipe_checker.sv
module mod_mul_pipe_checker #(
  parameter int N = 18,
  parameter int K = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_res
);
  localparam int LAT = mm_pkg::pipe_depth(K);
  localparam int CNW = $clog2(LAT + 2) + 1;
  localparam logic [N:0] MODV = (N+1)'((64'd1 << N) - 64'(K));

  logic [CNW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + CNW'(in_valid && in_ready) - CNW'(out_valid && out_ready);
  end

  assert_res_below_modulus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_res} < MODV));

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

  assert_empty_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_inflight_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNW'(LAT));
endmodule

bind mod_mul_pipe mod_mul_pipe_checker #(.N(N), .K(K)) u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res)
);

// File: tb/mod_mul_pipe_bench.sv
module mod_mul_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 18;
  localparam int NDUT = 4;
  localparam int KS [NDUT] = '{3, 1, 17, 45};
  localparam logic [N-1:0] MAXV = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_b = '0;
  logic ordy0 = 1'b1;

  logic ordy [NDUT];
  logic irdy [NDUT];
  logic ov   [NDUT];
  logic [N-1:0] ores [NDUT];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ordy[0] = ordy0;
  assign ordy[1] = 1'b1;
  assign ordy[2] = 1'b1;
  assign ordy[3] = 1'b1;

  task automatic check_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  for (genvar g = 0; g < NDUT; g++) begin : g_dut
    localparam longint MODG = (longint'(1) << N) - longint'(KS[g]);
    longint unsigned expq [$];

    mod_mul_pipe #(.N(N), .K(KS[g])) u_mod_mul_pipe (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(irdy[g]),
      .in_a(in_a), .in_b(in_b), .out_valid(ov[g]), .out_ready(ordy[g]),
      .out_res(ores[g])
    );

    // Scoreboard: handshakes are sampled mid-cycle, ahead of the edge.
    always @(negedge clk) begin : mon
      longint unsigned e;
      if (rst_n) begin
        if (ov[g] && ordy[g]) begin
          checks++;
          if (expq.size() == 0) begin
            errors++;
            $display("FAIL R1 k=%0d: actual output %0d expected none", KS[g], ores[g]);
          end else begin
            e = expq.pop_front();
            if (longint'(ores[g]) != longint'(e)) begin
              errors++;
              $display("FAIL R1 k=%0d: actual %0d expected %0d", KS[g], ores[g], e);
            end
          end
          checks++;
          if (longint'(ores[g]) >= MODG) begin
            errors++;
            $display("FAIL R4 k=%0d: actual %0d expected below %0d", KS[g], ores[g], MODG);
          end
        end
        if (in_valid && irdy[g])
          expq.push_back((longint'(in_a) * longint'(in_b)) % MODG);
      end
    end
  end

  task automatic send(input logic [N-1:0] a, input logic [N-1:0] b);
    @(posedge clk); #1;
    in_valid = 1'b1; in_a = a; in_b = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic t_reset;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    for (int g = 0; g < NDUT; g++) begin
      check_eq("R8 out_valid low after reset", longint'(ov[g]), 0);
      check_eq("R8 in_ready high after reset", longint'(irdy[g]), 1);
    end
  endtask

  task automatic t_latency;
    int lat [NDUT];
    for (int g = 0; g < NDUT; g++) lat[g] = -1;
    send(18'd5, 18'd7);
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk); #1;
      if (c == 1) in_valid = 1'b0;
      for (int g = 0; g < NDUT; g++)
        if (ov[g] && lat[g] < 0) lat[g] = c;
    end
    check_eq("R2 latency k=3", lat[0], 5);
    check_eq("R3 latency k=1", lat[1], 3);
    check_eq("R2 latency k=17", lat[2], 5);
    check_eq("R2 latency k=45", lat[3], 5);
    idle(4);
  endtask

  task automatic t_corners;
    // Largest operands, values at and above each modulus, powers of two.
    send(18'd0, 18'd0);
    send(18'd0, MAXV);
    send(18'd1, MAXV);
    send(MAXV, MAXV);
    send(MAXV, 18'd1);
    send(MAXV - 18'd2, MAXV - 18'd2);
    send(MAXV - 18'd16, MAXV - 18'd16);
    send(MAXV - 18'd44, MAXV - 18'd44);
    send(MAXV - 18'd1, MAXV);
    send(18'h20000, 18'h20000);
    send(18'h3FFF0, 18'h2AAAA);
    idle(10);
    // K = 1: product congruent to zero must come out as 0, never all ones.
    send(MAXV, MAXV);
    for (int c = 1; c <= 3; c++) begin
      @(posedge clk); #1;
      if (c == 1) in_valid = 1'b0;
    end
    check_eq("R4 k=1 valid for all-ones product", longint'(ov[1]), 1);
    check_eq("R4 k=1 all-ones product maps to zero", longint'(ores[1]), 0);
    idle(6);
  endtask

  task automatic t_pattern;
    logic [15:0] pat = 16'b1110_0100_1111_1101;
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #1;
      if (i >= 1) begin
        check_eq("R7 bubble / R5 stream k=3 out_valid", longint'(ov[0]),
                 (i - 5 >= 0 && i - 5 < 16) ? longint'(pat[i-5]) : 0);
        check_eq("R7 bubble / R5 stream k=1 out_valid", longint'(ov[1]),
                 (i - 3 >= 0 && i - 3 < 16) ? longint'(pat[i-3]) : 0);
      end
      in_valid = (i < 16) ? pat[i] : 1'b0;
      in_a = N'($urandom);
      in_b = N'($urandom);
    end
    idle(4);
  endtask

  task automatic t_stall;
    bit was_stall = 1'b0;
    bit was_acc = 1'b0;
    logic [N-1:0] held = '0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      if (was_stall) begin
        check_eq("R6 out_valid held during stall", longint'(ov[0]), 1);
        check_eq("R6 out_res held during stall", longint'(ores[0]), longint'(held));
      end
      if (!in_valid || was_acc) begin
        in_valid = ($urandom % 4) != 0;
        in_a = N'($urandom);
        in_b = N'($urandom);
      end
      ordy0 = ($urandom % 3) != 0;
      #1;
      was_stall = ov[0] && !ordy0;
      held = ores[0];
      was_acc = in_valid && irdy[0];
      if (was_stall)
        check_eq("R6 in_ready low during stall", longint'(irdy[0]), 0);
    end
    @(posedge clk); #1;
    ordy0 = 1'b1;
    in_valid = 1'b0;
    idle(12);
  endtask

  task automatic t_drain;
    check_eq("R1 k=3 all results delivered", g_dut[0].expq.size(), 0);
    check_eq("R1 k=1 all results delivered", g_dut[1].expq.size(), 0);
    check_eq("R1 k=17 all results delivered", g_dut[2].expq.size(), 0);
    check_eq("R1 k=45 all results delivered", g_dut[3].expq.size(), 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_pattern();
    t_stall();
    t_drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule